// File: doc/BRIEF.md
# Cluster Power-Down Controller

This block takes one core of a four-core cluster out of service and, when that core is the last one running, powers down the whole cluster. It keeps an occupancy bit for each core. A power-up pulse sets the bit and a die pulse clears it. A kill request names the core to shut down. The controller then polls that core's wait-for-interrupt status once per poll period. While the core is still marked occupied, a poll only waits and does not read the status.

When the core reports idle, the controller sets the core's power-gating bit. After a settle delay it asks an external power switch to close and waits for the switch to answer. If no core in the cluster is occupied after that, it polls the cluster L2 idle status with the same period and limit. Once the L2 is idle, it drives the three active-low cluster resets low and then sets the cluster gating bit. A core that never goes idle ends the request with a timeout flag and nothing powered down. An L2 that never goes idle ends the request as a success, and the cluster stays powered.

All delays are given in clock cycles: the poll period, the poll limit and the settle time. A parameter picks where the cluster gating bit sits in the gating word.

Top module: `cluster_pdn_ctrl`

## Requirements
- R1: After reset, gate_o is all zero, the three reset outputs are high, and sw_close_req_o, done_o and timeout_o are low.
- R2: Only core 0 is occupied after reset. An up_i pulse marks core up_core_i occupied, and a die_i pulse marks core die_core_i free. If both pulses name the same core in the same cycle, up_i wins.
- R3: After a kill, the core status is examined only at the end of each POLL_CYCLES period. A period in which the target is occupied, or its wfi_i bit is low, counts as a failed poll.
- R4: After POLL_LIMIT failed core polls, done_o pulses with timeout_o high and gate_o unchanged, and no switch request is made. This takes at least POLL_CYCLES*POLL_LIMIT cycles.
- R5: When a core poll succeeds, the core's gating bit is set. With CLUSTER_GATE_LOW=1, core 0 maps to bit NUM_CORES and core n>0 maps to bit n. With CLUSTER_GATE_LOW=0, core n maps to bit n.
- R6: At least SETTLE_CYCLES cycles after the core gating bit is set, sw_close_req_o rises. It stays high until sw_done_i is seen.
- R7: If any core is still occupied after the switch closes, done_o pulses with timeout_o low and no cluster action is taken.
- R8: If no core is occupied, L2 idle is polled in the same way. After POLL_LIMIT failed polls, done_o pulses with timeout_o low, the resets stay high and the cluster gating bit stays clear.
- R9: When L2 idle is seen, the three reset outputs go low together. The cluster gating bit is set one cycle later: bit 0 if CLUSTER_GATE_LOW=1, bit NUM_CORES otherwise. done_o follows at least SETTLE_CYCLES cycles after that.
- R10: done_o is a single-cycle pulse, with one pulse per accepted kill. A kill_i that arrives while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kill_i | input | 1 | Start shutdown of core kill_core_i |
| kill_core_i | input | log2(NUM_CORES) | Core to shut down |
| up_i | input | 1 | Mark core up_core_i occupied |
| up_core_i | input | log2(NUM_CORES) | Core index for up_i |
| die_i | input | 1 | Mark core die_core_i free |
| die_core_i | input | log2(NUM_CORES) | Core index for die_i |
| wfi_i | input | NUM_CORES | Per-core wait-for-interrupt status |
| l2_idle_i | input | 1 | Cluster L2 idle status |
| sw_done_i | input | 1 | Power switch close finished |
| gate_o | output | NUM_CORES+1 | Power-gating bits for the cores and the cluster |
| sw_close_req_o | output | 1 | Request to close the core power switch |
| dbg_soc_rst_n_o | output | 1 | Cluster debug reset, active low |
| bus_rst_n_o | output | 1 | Cluster bus reset, active low |
| l2_rst_n_o | output | 1 | Cluster L2 reset, active low |
| done_o | output | 1 | Request finished (one-cycle pulse) |
| timeout_o | output | 1 | Last request ended because the core never went idle |

## Verification
Some properties are checked by assertions on every cycle. Gating bits are never cleared, and a timeout never changes gating. The switch request holds until it is answered. The cluster resets move together and are low before the cluster gating bit rises. done_o is a single-cycle pulse, and up and die pulses update occupancy. Other behaviour only the bench scenarios can show. These are the bit mapping of each core in the swapped mode, and the waiting on occupied cores. They also cover the choice between stopping at core level and going on to cluster level, the L2 timeout being reported as success, the minimum poll and settle durations, and a kill that arrives mid-request being ignored.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_CPOLL,
    S_CSETTLE,
    S_SWREQ,
    S_CLCHK,
    S_LPOLL,
    S_CLRST,
    S_CLGATE,
    S_CLSETTLE
  } cpd_state_e;
endpackage

// File: rtl/cpd_occupancy.sv
module cpd_occupancy #(
  parameter int NUM_CORES = 4,
  parameter logic [NUM_CORES-1:0] BOOT_OCC = 1,
  localparam int IW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 up_i,
  input  logic [IW-1:0]        up_idx_i,
  input  logic                 die_i,
  input  logic [IW-1:0]        die_idx_i,
  output logic [NUM_CORES-1:0] occ_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      occ_o <= BOOT_OCC;
    end else begin
      if (die_i) occ_o[die_idx_i] <= 1'b0;
      if (up_i)  occ_o[up_idx_i]  <= 1'b1;
    end
  end

  AST_UP_SETS: assert property (@(posedge clk) disable iff (rst)
    up_i |=> occ_o[$past(up_idx_i)]); // R2
  AST_DIE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (die_i && !(up_i && up_idx_i == die_idx_i)) |=> !occ_o[$past(die_idx_i)]); // R2
endmodule

// File: rtl/cpd_poll_timer.sv
module cpd_poll_timer #(
  parameter int PERIOD = 12500,
  parameter int LIMIT  = 1000,
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  output logic tick_o,
  output logic last_o
);
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tries_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q   <= '0;
      tries_q <= '0;
    end else if (cnt_q == CW'(PERIOD - 1)) begin
      cnt_q   <= '0;
      tries_q <= tries_q + TW'(1);
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign tick_o = !clear_i && (cnt_q == CW'(PERIOD - 1));
  assign last_o = (tries_q == TW'(LIMIT - 1));

  AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !clear_i) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/cpd_gate_map.sv
module cpd_gate_map #(
  parameter int NUM_CORES = 4,
  parameter bit CLUSTER_GATE_LOW = 1'b1,
  localparam int IW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int GW = NUM_CORES + 1
) (
  input  logic [IW-1:0] core_idx_i,
  output logic [GW-1:0] core_mask_o,
  output logic [GW-1:0] cluster_mask_o
);
  localparam logic [GW-1:0] ONE = GW'(1);

  generate
    if (CLUSTER_GATE_LOW) begin : g_low
      always_comb begin
        core_mask_o = '0;
        if (core_idx_i == '0) core_mask_o[NUM_CORES] = 1'b1;
        else                  core_mask_o[core_idx_i] = 1'b1;
      end
      assign cluster_mask_o = ONE;
    end else begin : g_high
      always_comb begin
        core_mask_o = '0;
        core_mask_o[core_idx_i] = 1'b1;
      end
      assign cluster_mask_o = ONE << NUM_CORES;
    end
  endgenerate
endmodule

// File: rtl/cluster_pdn_ctrl.sv
module cluster_pdn_ctrl #(
  parameter int NUM_CORES = 4,
  parameter int POLL_CYCLES = 12500,
  parameter int POLL_LIMIT = 1000,
  parameter int SETTLE_CYCLES = 2500,
  parameter bit CLUSTER_GATE_LOW = 1'b1,
  parameter logic [NUM_CORES-1:0] BOOT_OCC = 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              kill_i,
  input  logic [$clog2(NUM_CORES)-1:0]      kill_core_i,
  input  logic                              up_i,
  input  logic [$clog2(NUM_CORES)-1:0]      up_core_i,
  input  logic                              die_i,
  input  logic [$clog2(NUM_CORES)-1:0]      die_core_i,
  input  logic [NUM_CORES-1:0]              wfi_i,
  input  logic                              l2_idle_i,
  input  logic                              sw_done_i,
  output logic [NUM_CORES:0]                gate_o,
  output logic                              sw_close_req_o,
  output logic                              dbg_soc_rst_n_o,
  output logic                              bus_rst_n_o,
  output logic                              l2_rst_n_o,
  output logic                              done_o,
  output logic                              timeout_o
);
  import cpd_pkg::*;

  localparam int IW = $clog2(NUM_CORES);
  localparam int GW = NUM_CORES + 1;
  localparam int CL_BIT = CLUSTER_GATE_LOW ? 0 : NUM_CORES;

  cpd_state_e     state_q;
  logic [IW-1:0]  tgt_q;
  logic [NUM_CORES-1:0] occ;
  logic [GW-1:0]  core_mask, cluster_mask;
  logic           p_clear, p_tick, p_last;
  logic           s_clear, s_tick, s_last;

  cpd_occupancy #(.NUM_CORES(NUM_CORES), .BOOT_OCC(BOOT_OCC)) u_occ (
    .clk(clk), .rst(rst), .up_i(up_i), .up_idx_i(up_core_i),
    .die_i(die_i), .die_idx_i(die_core_i), .occ_o(occ));

  cpd_gate_map #(.NUM_CORES(NUM_CORES), .CLUSTER_GATE_LOW(CLUSTER_GATE_LOW)) u_map (
    .core_idx_i(tgt_q), .core_mask_o(core_mask), .cluster_mask_o(cluster_mask));

  assign p_clear = (state_q != S_CPOLL) && (state_q != S_LPOLL);
  assign s_clear = (state_q != S_CSETTLE) && (state_q != S_CLSETTLE);

  cpd_poll_timer #(.PERIOD(POLL_CYCLES), .LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst(rst), .clear_i(p_clear), .tick_o(p_tick), .last_o(p_last));

  cpd_poll_timer #(.PERIOD(SETTLE_CYCLES), .LIMIT(1)) u_settle (
    .clk(clk), .rst(rst), .clear_i(s_clear), .tick_o(s_tick), .last_o(s_last));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= S_IDLE;
      tgt_q           <= '0;
      gate_o          <= '0;
      sw_close_req_o  <= 1'b0;
      dbg_soc_rst_n_o <= 1'b1;
      bus_rst_n_o     <= 1'b1;
      l2_rst_n_o      <= 1'b1;
      done_o          <= 1'b0;
      timeout_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (kill_i) begin
          tgt_q   <= kill_core_i;
          state_q <= S_CPOLL;
        end
        S_CPOLL: if (p_tick) begin
          if (!occ[tgt_q] && wfi_i[tgt_q]) begin
            gate_o  <= gate_o | core_mask;
            state_q <= S_CSETTLE;
          end else if (p_last) begin
            done_o    <= 1'b1;
            timeout_o <= 1'b1;
            state_q   <= S_IDLE;
          end
        end
        S_CSETTLE: if (s_tick) begin
          sw_close_req_o <= 1'b1;
          state_q        <= S_SWREQ;
        end
        S_SWREQ: if (sw_done_i) begin
          sw_close_req_o <= 1'b0;
          state_q        <= S_CLCHK;
        end
        S_CLCHK: begin
          if (occ == '0) begin
            state_q <= S_LPOLL;
          end else begin
            done_o    <= 1'b1;
            timeout_o <= 1'b0;
            state_q   <= S_IDLE;
          end
        end
        S_LPOLL: if (p_tick) begin
          if (l2_idle_i) begin
            state_q <= S_CLRST;
          end else if (p_last) begin
            done_o    <= 1'b1;
            timeout_o <= 1'b0;
            state_q   <= S_IDLE;
          end
        end
        S_CLRST: begin
          dbg_soc_rst_n_o <= 1'b0;
          bus_rst_n_o     <= 1'b0;
          l2_rst_n_o      <= 1'b0;
          state_q         <= S_CLGATE;
        end
        S_CLGATE: begin
          gate_o  <= gate_o | cluster_mask;
          state_q <= S_CLSETTLE;
        end
        S_CLSETTLE: if (s_tick) begin
          done_o    <= 1'b1;
          timeout_o <= 1'b0;
          state_q   <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_GATE_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((gate_o & $past(gate_o)) == $past(gate_o))); // R5
  AST_TOUT_NO_GATE: assert property (@(posedge clk) disable iff (rst)
    (done_o && timeout_o) |-> (gate_o == $past(gate_o))); // R4
  AST_SWREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sw_close_req_o && !sw_done_i) |=> sw_close_req_o); // R6
  AST_RST_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (dbg_soc_rst_n_o == l2_rst_n_o) && (bus_rst_n_o == l2_rst_n_o)); // R9
  AST_RST_BEFORE_GATE: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o[CL_BIT]) |-> (!l2_rst_n_o && $past(!l2_rst_n_o))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10
endmodule

// File: tb/cluster_pdn_ctrl_bench.sv
module cluster_pdn_ctrl_bench;
  localparam int N = 4;
  localparam int PC = 4;
  localparam int PL = 3;
  localparam int ST = 5;

  typedef struct {
    logic [N:0] gate;
    logic       tout;
    logic [2:0] rsts;
    int         min_el;
    int         start;
    string      tag;
  } item_t;

  logic clk = 0, rst = 1;
  logic kill = 0, up = 0, die = 0, l2 = 0, swd = 0;
  logic [1:0] kidx = 0, uidx = 0, didx = 0;
  logic [N-1:0] wfi = 0;
  logic [N:0] gate;
  logic swreq, rd, rb, rl, done, tout;

  int total = 0, bad = 0, n_done = 0, cyc = 0;
  int gate_cyc = 0;
  bit finished = 0;
  item_t exp_q[$];
  logic [N:0] prev_gate = 0;
  logic prev_req = 0, prev_l2 = 1;

  cluster_pdn_ctrl #(.NUM_CORES(N), .POLL_CYCLES(PC), .POLL_LIMIT(PL),
    .SETTLE_CYCLES(ST), .CLUSTER_GATE_LOW(1'b1), .BOOT_OCC(4'b0001)) u_cluster_pdn_ctrl (
    .clk(clk), .rst(rst), .kill_i(kill), .kill_core_i(kidx), .up_i(up), .up_core_i(uidx),
    .die_i(die), .die_core_i(didx), .wfi_i(wfi), .l2_idle_i(l2), .sw_done_i(swd),
    .gate_o(gate), .sw_close_req_o(swreq), .dbg_soc_rst_n_o(rd), .bus_rst_n_o(rb),
    .l2_rst_n_o(rl), .done_o(done), .timeout_o(tout));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (gate != prev_gate) gate_cyc = cyc;
      if (swreq && !prev_req)
        chk(cyc - gate_cyc >= ST, "R6", "settle before switch request", cyc - gate_cyc, ST);
      if (gate[0] && !prev_gate[0])
        chk(!rl && !prev_l2, "R9", "resets low before cluster gate", int'(rl), 0);
      if (done) begin
        n_done++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(gate == it.gate, it.tag, "gate", int'(gate), int'(it.gate));
          chk(tout == it.tout, it.tag, "timeout", int'(tout), int'(it.tout));
          chk({rd, rb, rl} == it.rsts, it.tag, "resets", int'({rd, rb, rl}), int'(it.rsts));
          chk(cyc - it.start >= it.min_el, it.tag, "elapsed", cyc - it.start, it.min_el);
        end
      end
      prev_gate = gate;
      prev_req = swreq;
      prev_l2 = rl;
    end
  end

  // power switch responder
  initial begin
    forever begin
      @(negedge clk);
      if (swreq && !swd) begin
        repeat (2) @(negedge clk);
        swd = 1;
        @(negedge clk);
        swd = 0;
      end
    end
  end

  task automatic pulse_up(input int i);
    @(negedge clk); up = 1; uidx = 2'(i);
    @(negedge clk); up = 0;
  endtask

  task automatic pulse_die(input int i);
    @(negedge clk); die = 1; didx = 2'(i);
    @(negedge clk); die = 0;
  endtask

  task automatic drive_kill(input int i, input logic [N:0] g, input logic t,
                            input logic [2:0] r, input int mel, input string tag);
    item_t it;
    it.gate = g; it.tout = t; it.rsts = r; it.min_el = mel; it.tag = tag;
    @(negedge clk);
    it.start = cyc;
    exp_q.push_back(it);
    kill = 1; kidx = 2'(i);
    @(negedge clk);
    kill = 0;
  endtask

  task automatic wait_done(input int k);
    while (n_done < k) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(gate == 0, "R1", "gate after reset", int'(gate), 0);
    chk({rd, rb, rl} == 3'b111, "R1", "resets after reset", int'({rd, rb, rl}), 7);
    chk(!swreq, "R1", "switch request after reset", int'(swreq), 0);
    chk(!done && !tout, "R1", "done/timeout after reset", int'({done, tout}), 0);

    // R2: cores 1 and 2 come up; core 0 occupied from reset
    pulse_up(1);
    pulse_up(2);

    // R5/R7: free core 3 goes down, others occupied -> no cluster action
    wfi = 4'b1000;
    drive_kill(3, 5'b01000, 1'b0, 3'b111, PC, "R7");
    wait_done(1);

    // R3/R4: occupied core 1 with wfi set -> timeout, no gating
    wfi = 4'b1010;
    drive_kill(1, 5'b01000, 1'b1, 3'b111, PC * PL, "R4");
    wait_done(2);

    // R3/R5: core 2 freed, wfi late
    pulse_die(1);
    pulse_die(2);
    wfi = 4'b1000;
    drive_kill(2, 5'b01100, 1'b0, 3'b111, PC, "R3");
    repeat (6) @(negedge clk);
    wfi = 4'b1100;
    wait_done(3);

    // R8: all cores free, L2 never idle -> success, cluster kept
    pulse_die(0);
    wfi = 4'b1110;
    l2 = 0;
    drive_kill(1, 5'b01110, 1'b0, 3'b111, PC * (PL + 1), "R8");
    wait_done(4);

    // R5 swap / R9: core 0 to bit 4, cluster bit 0, resets low; R10 extra kill ignored
    wfi = 4'b1111;
    l2 = 1;
    drive_kill(0, 5'b11111, 1'b0, 3'b000, 2 * PC + ST, "R9");
    repeat (3) @(negedge clk);
    kill = 1; kidx = 2'd3;
    @(negedge clk); kill = 0;
    wait_done(5);
    repeat (60) @(negedge clk);
    chk(n_done == 5, "R10", "done count after ignored kill", n_done, 5);
    chk(exp_q.size() == 0, "R10", "pending expectations", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end
endmodule